// File: doc/BRIEF.md
# Keyed Reset Pulse Configuration and Generator

This block holds the configuration of the external reset pulse that a watchdog drives, and generates that pulse. Software writes one 32-bit configuration word. The top byte of each write is a command key. Four key values each set or clear one of two sticky flags: the level polarity and the drive type. Every other key value leaves both flags as they were. The low 20 bits of every write replace the pulse width, whatever the key.

When the countdown logic outside this block raises a trigger, the block produces one pulse at the active level. The pulse lasts the programmed number of clock cycles. An output-enable is driven beside the pulse, which lets the pad outside the block act as open-drain or push-pull. The full stored word can be read back at all times.

Top module: `wdog_rst_pulse`

## Requirements
- R1: After reset the configuration word reads 0x000000FF. The output is at the inactive level (high, because the polarity flag is clear) and the output-enable is low.
- R2: A write whose bits [31:24] equal 0xA5 sets bit 31, the active-high polarity flag. A write whose bits [31:24] equal 0x5A clears it.
- R3: A write whose bits [31:24] equal 0xA8 sets bit 30, the push-pull flag. A write whose bits [31:24] equal 0x8A clears it.
- R4: A write with any other value in bits [31:24], including zero, leaves bits 31 and 30 unchanged.
- R5: Every write replaces bits [19:0], the pulse width, with the written data. Bits [29:20] are never changed by a write.
- R6: A trigger sampled while no pulse is running starts a pulse on the next clock edge. The pulse holds the output at the active level for exactly the programmed width in clock cycles. The active level is high when bit 31 is set and low when it is clear.
- R7: A programmed width of 0 gives a pulse of one clock cycle.
- R8: In open-drain mode (bit 30 clear), the output-enable is high only while the active level is driven. In push-pull mode (bit 30 set), the output-enable stays high at all times.
- R9: A trigger that arrives while a pulse is running is ignored. The running pulse keeps its length and no second pulse follows.
- R10: The read port always returns the full stored 32-bit configuration word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that also times the pulse width |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data: key in [31:24], width in [19:0] |
| rd_data | output | 32 | Stored configuration word |
| trig | input | 1 | Request to emit one reset pulse |
| pulse_out | output | 1 | Reset pulse level |
| pulse_oe | output | 1 | Output-enable for the pad driver |

## Verification
The assertions assume that wr_en, wr_data and trig are synchronous to clk and hold steady around each rising edge. They also assume that a write landing during a pulse may change the polarity mid-pulse, so none of them ties the output level to the flags as they stood when the pulse started. The stimulus changes every input only on the falling edge. It rewrites the configuration only while the output is idle, and it samples outputs on the falling edge, so each measured pulse is taken under one fixed setting.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned KEY_W    = 8;
  localparam int unsigned NFLAG    = 2;
  // flag index 0 -> drive type (push-pull), index 1 -> polarity (active high)
  localparam logic [KEY_W-1:0] KEY_PP_SET  = 8'hA8;
  localparam logic [KEY_W-1:0] KEY_PP_CLR  = 8'h8A;
  localparam logic [KEY_W-1:0] KEY_POL_SET = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_POL_CLR = 8'h5A;
  localparam logic [NFLAG-1:0][KEY_W-1:0] SET_KEYS = {KEY_POL_SET, KEY_PP_SET};
  localparam logic [NFLAG-1:0][KEY_W-1:0] CLR_KEYS = {KEY_POL_CLR, KEY_PP_CLR};
endpackage

// File: rtl/wrp_key_decode.sv
module wrp_key_decode
  import wrp_pkg::*;
#(
  parameter int unsigned N = NFLAG
) (
  input  logic [KEY_W-1:0] key,
  output logic [N-1:0]     set_o,
  output logic [N-1:0]     clr_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    assign set_o[i] = (key == SET_KEYS[i]);
    assign clr_o[i] = (key == CLR_KEYS[i]);
  end
endmodule

// File: rtl/wrp_cfg_reg.sv
module wrp_cfg_reg #(
  parameter int unsigned          DW      = 32,
  parameter int unsigned          WID_W   = 20,
  parameter int unsigned          N       = 2,
  parameter logic [DW-1:0]        RST_VAL = 32'h0000_00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  output logic [DW-1:0] cfg_q
);
  localparam int unsigned FLAG_LSB = DW - N;

  logic [DW-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    cfg_d[WID_W-1:0] = wr_data[WID_W-1:0];
    for (int i = 0; i < int'(N); i++) begin
      if (set_i[i])      cfg_d[FLAG_LSB+i] = 1'b1;
      else if (clr_i[i]) cfg_d[FLAG_LSB+i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= RST_VAL;
    else if (wr_en) cfg_q <= cfg_d;
  end

  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (set_i == '0) && (clr_i == '0)) |=> $stable(cfg_q[DW-1:FLAG_LSB])); // R4
  AST_WIDTH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[WID_W-1:0] == $past(wr_data[WID_W-1:0]))); // R5
  AST_MID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(cfg_q[FLAG_LSB-1:WID_W])); // R5
endmodule

// File: rtl/wrp_pulse_gen.sv
module wrp_pulse_gen #(
  parameter int unsigned WID_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [WID_W-1:0] width,
  output logic             active
);
  logic [WID_W-1:0] cnt_q, cnt_d;
  logic [WID_W-1:0] eff_w;
  logic             cnt_en;

  assign eff_w  = (width == '0) ? WID_W'(1) : width;
  assign active = (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (active) begin
      cnt_d  = cnt_q - WID_W'(1);
      cnt_en = 1'b1;
    end else if (trig) begin
      cnt_d  = eff_w;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && trig) |=> active); // R7
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cnt_q == $past(cnt_q) - WID_W'(1))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !trig) |=> !active); // R6
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse
  import wrp_pkg::*;
#(
  parameter int unsigned        WID_W   = 20,
  parameter logic [DATA_W-1:0]  RST_VAL = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              trig,
  output logic              pulse_out,
  output logic              pulse_oe
);
  localparam int unsigned POL_BIT = DATA_W - 1;
  localparam int unsigned PP_BIT  = DATA_W - 2;

  logic [NFLAG-1:0]  set_w, clr_w;
  logic [DATA_W-1:0] cfg_q;
  logic              active;
  logic              pol_hi, push_pull;

  wrp_key_decode #(.N(NFLAG)) u_dec (
    .key   (wr_data[DATA_W-1 -: KEY_W]),
    .set_o (set_w),
    .clr_o (clr_w)
  );

  wrp_cfg_reg #(.DW(DATA_W), .WID_W(WID_W), .N(NFLAG), .RST_VAL(RST_VAL)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en & 1'b1),
    .wr_data (wr_data),
    .set_i   (set_w),
    .clr_i   (clr_w),
    .cfg_q   (cfg_q)
  );

  wrp_pulse_gen #(.WID_W(WID_W)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig),
    .width  (cfg_q[WID_W-1:0]),
    .active (active)
  );

  assign pol_hi    = cfg_q[POL_BIT];
  assign push_pull = cfg_q[PP_BIT];
  assign rd_data   = cfg_q;
  assign pulse_out = active ? pol_hi : ~pol_hi;
  assign pulse_oe  = push_pull | active;

  AST_POL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DATA_W-1 -: KEY_W] == 8'hA5) |=> rd_data[POL_BIT]); // R2
  AST_POL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DATA_W-1 -: KEY_W] == 8'h5A) |=> !rd_data[POL_BIT]); // R2
  AST_PP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DATA_W-1 -: KEY_W] == 8'hA8) |=> rd_data[PP_BIT]); // R3
  AST_PP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DATA_W-1 -: KEY_W] == 8'h8A) |=> !rd_data[PP_BIT]); // R3
  AST_OD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_oe && !rd_data[PP_BIT]) |-> (pulse_out == rd_data[POL_BIT])); // R8
endmodule

// File: tb/wdog_rst_pulse_bench.sv
module wdog_rst_pulse_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        trig;
  logic        pulse_out;
  logic        pulse_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_rst_pulse u_wdog_rst_pulse (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trig(trig), .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // trigger held for hold cycles; returns active length and whether oe stayed high
  task automatic fire(input int hold, input logic act_lvl, output int n, output bit oe_all);
    n = 0; oe_all = 1;
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    for (int k = 1; k < hold; k++) begin
      if (pulse_out === act_lvl) begin n++; if (pulse_oe !== 1'b1) oe_all = 0; end
      @(negedge clk);
    end
    trig = 1'b0;
    while (pulse_out === act_lvl && n < 100) begin
      n++; if (pulse_oe !== 1'b1) oe_all = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset word", rd_data, 32'h0000_00FF);
    chk("R1 idle level", {31'b0, pulse_out}, 32'd1);
    chk("R1 idle oe", {31'b0, pulse_oe}, 32'd0);
  endtask

  task automatic t_keys;
    wr(32'hA500_0003); chk("R2 pol set", rd_data, 32'h8000_0003);
    wr(32'hA800_0004); chk("R3 pp set", rd_data, 32'hC000_0004);
    wr(32'h0000_0005); chk("R4 zero key", rd_data, 32'hC000_0005);
    wr(32'h5B00_0006); chk("R4 other key", rd_data, 32'hC000_0006);
    wr(32'h5A00_0007); chk("R2 pol clr", rd_data, 32'h4000_0007);
    wr(32'h8A00_0008); chk("R3 pp clr", rd_data, 32'h0000_0008);
  endtask

  task automatic t_width;
    wr(32'h00FF_FFFF); chk("R5 width and mid bits", rd_data, 32'h000F_FFFF);
    wr(32'hA53F_1234); chk("R10 full readback", rd_data, 32'h800F_1234);
    wr(32'h5A00_0000);
  endtask

  task automatic t_pulse_od_low;
    int n; bit oe;
    wr(32'h0000_0003);
    fire(1, 1'b0, n, oe);
    chk("R6 low pulse len", n, 3);
    chk("R8 od oe during pulse", {31'b0, oe}, 32'd1);
    chk("R8 od oe idle", {31'b0, pulse_oe}, 32'd0);
    chk("R6 back to idle", {31'b0, pulse_out}, 32'd1);
  endtask

  task automatic t_pulse_hi_pp;
    int n; bit oe;
    wr(32'hA500_0004); wr(32'hA800_0004);
    chk("R6 high idle level", {31'b0, pulse_out}, 32'd0);
    chk("R8 pp oe idle", {31'b0, pulse_oe}, 32'd1);
    fire(1, 1'b1, n, oe);
    chk("R6 high pulse len", n, 4);
    chk("R8 pp oe during", {31'b0, oe}, 32'd1);
    chk("R8 pp oe after", {31'b0, pulse_oe}, 32'd1);
    wr(32'h5A00_0000); wr(32'h8A00_0000);
  endtask

  task automatic t_zero_width;
    int n; bit oe;
    wr(32'h0000_0000);
    fire(1, 1'b0, n, oe);
    chk("R7 zero width gives one", n, 1);
  endtask

  task automatic t_retrig;
    int n; bit oe;
    wr(32'h0000_0005);
    fire(4, 1'b0, n, oe);
    chk("R9 retrigger ignored len", n, 5);
    for (int k = 0; k < 3; k++) begin
      chk("R9 no second pulse", {31'b0, pulse_out}, 32'd1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_keys;
    t_width;
    t_pulse_od_low;
    t_pulse_hi_pp;
    t_zero_width;
    t_retrig;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule